// File: doc/BRIEF.md
# Data Tenure Scheduler with Write Bypass

This block chooses the order in which a pipelined bus master runs its data phases. Each time an address phase finishes, the surrounding logic pushes a record into the block: a tag and a read/write flag. Later, the system arbiter grants the data bus. The block then picks one held record and keeps the bus until the beat logic reports that the transfer is done. When that happens, the record leaves the queue.

By default, records run in the order they arrived. A priority strobe is sampled together with the grant. When it is high, the oldest held write runs first, even if an older read is waiting. The usual reason is to let a line copy-back go out ahead of a pending read. If the strobe is high but no write is held, the oldest read runs instead. The block still takes the bus in that case. The beat-level transfer and the address phase are handled outside this block.

Top module: `data_tenure_sched`

## Requirements
- R1: The block holds at most DEPTH records, which is 2 by default. `pend_count` never goes above DEPTH, and the record that is running still counts as held.
- R2: The block accepts a grant when the bus is idle, `grant` is high and `wr_first` is low. It then runs the oldest held record.
- R3: The block accepts a grant when the bus is idle, `grant` and `wr_first` are both high, and a write is held. It then runs the oldest held write (`sel_is_write` = 1), even if an older read is held.
- R4: The block accepts a grant when the bus is idle, `grant` and `wr_first` are both high, and only reads are held. It still takes the bus and runs the oldest read (`sel_is_write` = 0).
- R5: When the bus is idle, at least one record is held and `grant` is high, `bus_busy` is high in the next cycle.
- R6: A grant that arrives while nothing is held has no effect: `bus_busy` stays low and `pend_count` stays 0.
- R7: When a record is removed after a bypass, the records that remain keep their arrival order.
- R8: An enqueue is dropped when DEPTH records are held and no record leaves in the same cycle. In that case `ovf_err` is high for exactly the next cycle and `pend_count` does not change.
- R9: An enqueue and a completion in the same cycle both take effect. `pend_count` changes by +1−1, and when the queue was full the new record is kept without an error.
- R10: From an accepted grant until `done`, `bus_busy` stays high and `sel_tag`/`sel_is_write` stay stable. Grants in this window are ignored. `deq_pulse` is high in exactly the cycles where `done` is high while the bus is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Push a finished address phase |
| enq_is_write | input | 1 | 1 = write record, 0 = read record |
| enq_tag | input | TAG_W | Identifier of the pushed record |
| grant | input | 1 | Qualified data-bus grant |
| wr_first | input | 1 | Write-priority strobe, sampled with `grant` |
| done | input | 1 | Running transfer has completed |
| bus_busy | output | 1 | Data bus owned by this master |
| sel_tag | output | TAG_W | Tag of the running record (0 when idle) |
| sel_is_write | output | 1 | Type of the running record (0 when idle) |
| deq_pulse | output | 1 | Running record is removed this cycle |
| pend_count | output | CNT_W | Number of records held |
| ovf_err | output | 1 | An enqueue was dropped in the previous cycle |

## Verification
The bench uses the defaults: DEPTH = 2 and TAG_W = 4. With only two slots, random pushes fill the queue quickly. This makes the drop path, enqueue while full during a completion, and bypasses of a read in slot 0 by a write in slot 1 occur often. A 4-bit tag wraps many times in a long run, so a record that runs out of order shows up as a wrong tag against the reference queue kept in the bench.

// File: rtl/dtq_pkg.sv
// Package dtq_pkg
// Shared types for the data tenure scheduler.
package dtq_pkg;
    // Ownership state of the data bus
    typedef enum logic {
        BUS_IDLE  = 1'b0,
        BUS_OWNED = 1'b1
    } bus_state_e;
endpackage

// File: rtl/dtq_store.sv
// Module dtq_store
// What it does: holds up to DEPTH records in arrival order, with slot 0 the
// oldest. A record can be removed from any slot; the slots after it shift
// down by one. A new record is appended after the survivors of that same
// cycle, so an enqueue and a removal in one cycle both take effect.
// Assumes: rm_idx points at a valid slot whenever rm_en is high.
module dtq_store #(
    parameter int DEPTH = 2,
    parameter int TAG_W = 4,
    parameter int CNT_W = 2,
    parameter int IDX_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enq_valid,
    input  logic                        enq_is_write,
    input  logic [TAG_W-1:0]            enq_tag,
    input  logic                        rm_en,
    input  logic [IDX_W-1:0]            rm_idx,
    output logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
    output logic [DEPTH-1:0]            slot_wr,
    output logic [DEPTH-1:0]            slot_vld,
    output logic [CNT_W-1:0]            count,
    output logic                        ovf_err
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cnt_after;
    logic             enq_acc;
    logic             ovf_q;

    // Occupancy after this cycle's removal, and whether the push fits
    always_comb begin
        cnt_after = count_q - CNT_W'(rm_en);
        enq_acc   = enq_valid && (cnt_after < CNT_W'(DEPTH));
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            logic [TAG_W-1:0] tag_q, tag_d;
            logic             wr_q,  wr_d;

            // Next slot content: shift on removal, then append
            always_comb begin
                tag_d = tag_q;
                wr_d  = wr_q;
                if (rm_en && (g >= int'(rm_idx))) begin
                    if (g < DEPTH - 1) begin
                        tag_d = g_slot[(g < DEPTH - 1) ? g + 1 : g].tag_q;
                        wr_d  = g_slot[(g < DEPTH - 1) ? g + 1 : g].wr_q;
                    end
                end
                if (enq_acc && (cnt_after == CNT_W'(g))) begin
                    tag_d = enq_tag;
                    wr_d  = enq_is_write;
                end
            end

            // Slot register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q <= '0;
                    wr_q  <= 1'b0;
                end else begin
                    tag_q <= tag_d;
                    wr_q  <= wr_d;
                end
            end

            assign slot_tag[g] = tag_q;
            assign slot_wr[g]  = wr_q;
            assign slot_vld[g] = (count_q > CNT_W'(g));
        end
    endgenerate

    // Occupancy counter and one-cycle drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            count_q <= cnt_after + CNT_W'(enq_acc);
            ovf_q   <= enq_valid && !enq_acc;
        end
    end

    assign count   = count_q;
    assign ovf_err = ovf_q;

    // R1: occupancy bound
    p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH))
        else $error("p_cap_r1");

    // R8: push into a full queue with no removal is dropped and flagged
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !rm_en && count_q == CNT_W'(DEPTH))
        |=> (ovf_q && count_q == $past(count_q)))
        else $error("p_no_overflow_r8");

    // R9: push during a completion on a full queue is kept
    p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && rm_en && count_q == CNT_W'(DEPTH))
        |=> (!ovf_q && count_q == CNT_W'(DEPTH)))
        else $error("p_swap_r9");
endmodule

// File: rtl/dtq_pick.sv
// Module dtq_pick
// What it does: chooses the slot to run on a grant. This is slot 0 (the oldest
// record), unless the write-priority strobe is high and some write is held;
// then it is the lowest-numbered write slot.
// Assumes: the valid slots are contiguous from slot 0.
module dtq_pick #(
    parameter int DEPTH = 2,
    parameter int IDX_W = 1
) (
    input  logic [DEPTH-1:0] slot_wr,
    input  logic [DEPTH-1:0] slot_vld,
    input  logic             wr_first,
    output logic [IDX_W-1:0] pick_idx,
    output logic             has_write
);
    logic [IDX_W-1:0] wr_idx;

    // Find the oldest held write by scanning from the young end
    always_comb begin
        wr_idx    = '0;
        has_write = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (slot_vld[i] && slot_wr[i]) begin
                wr_idx    = IDX_W'(i);
                has_write = 1'b1;
            end
        end
    end

    // Apply the priority strobe
    always_comb begin
        pick_idx = (wr_first && has_write) ? wr_idx : '0;
    end
endmodule

// File: rtl/dtq_ctrl.sv
// Module dtq_ctrl
// What it does: tracks whether this master owns the data bus. It takes the
// bus on a grant while records are held, latches which slot is running, and
// releases the bus and requests removal when done arrives.
// Assumes: the running slot stays in place while the bus is owned, because
// pushes only append behind it.
module dtq_ctrl
    import dtq_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] pick_idx,
    output logic             busy,
    output logic [IDX_W-1:0] cur_idx,
    output logic             rm_en
);
    bus_state_e       state_q;
    logic [IDX_W-1:0] cur_q;
    logic             take;

    // Decode acceptance and completion from the current state
    always_comb begin
        take  = (state_q == BUS_IDLE) && grant && (count != '0);
        rm_en = (state_q == BUS_OWNED) && done;
    end

    // Ownership state and running-slot register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            cur_q   <= '0;
        end else if (take) begin
            state_q <= BUS_OWNED;
            cur_q   <= pick_idx;
        end else if (rm_en) begin
            state_q <= BUS_IDLE;
        end
    end

    assign busy    = (state_q == BUS_OWNED);
    assign cur_idx = cur_q;

    // R5: grant with records held is taken
    p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && grant && count != '0) |=> busy)
        else $error("p_take_r5");

    // R6: grant with nothing held is ignored
    p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && count == '0) |=> !busy)
        else $error("p_empty_r6");

    // R10: ownership and running slot held until done
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(cur_q)))
        else $error("p_hold_r10");
endmodule

// File: rtl/data_tenure_sched.sv
// Module data_tenure_sched (top)
// What it does: schedules the data phases of a pipelined bus master. It
// queues finished address phases, picks one per data-bus grant (in order,
// or the oldest write first when wr_first is high), and holds the bus
// until done.
// Assumes: done is only meaningful while bus_busy is high.
module data_tenure_sched
    import dtq_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             enq_is_write,
    input  logic [TAG_W-1:0] enq_tag,
    input  logic             grant,
    input  logic             wr_first,
    input  logic             done,
    output logic             bus_busy,
    output logic [TAG_W-1:0] sel_tag,
    output logic             sel_is_write,
    output logic             deq_pulse,
    output logic [CNT_W-1:0] pend_count,
    output logic             ovf_err
);
    logic [DEPTH-1:0][TAG_W-1:0] slot_tag;
    logic [DEPTH-1:0]            slot_wr;
    logic [DEPTH-1:0]            slot_vld;
    logic [IDX_W-1:0]            pick_idx;
    logic [IDX_W-1:0]            cur_idx;
    logic                        has_write;
    logic                        rm_en;
    logic                        busy;

    dtq_store #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_is_write(enq_is_write), .enq_tag(enq_tag),
        .rm_en(rm_en), .rm_idx(cur_idx),
        .slot_tag(slot_tag), .slot_wr(slot_wr), .slot_vld(slot_vld),
        .count(pend_count), .ovf_err(ovf_err)
    );

    dtq_pick #(
        .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_pick (
        .slot_wr(slot_wr), .slot_vld(slot_vld), .wr_first(wr_first),
        .pick_idx(pick_idx), .has_write(has_write)
    );

    dtq_ctrl #(
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .grant(grant), .done(done),
        .count(pend_count), .pick_idx(pick_idx),
        .busy(busy), .cur_idx(cur_idx), .rm_en(rm_en)
    );

    // Present the running record; quiet zeros while idle
    always_comb begin
        sel_tag      = busy ? slot_tag[cur_idx] : '0;
        sel_is_write = busy ? slot_wr[cur_idx]  : 1'b0;
    end

    assign bus_busy  = busy;
    assign deq_pulse = rm_en;

    // R2: without priority the oldest record runs
    p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && grant && !wr_first && pend_count != '0) |=> (cur_idx == '0))
        else $error("p_in_order_r2");

    // R3: priority with a write held runs a write
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && grant && wr_first && has_write && pend_count != '0)
        |=> (busy && sel_is_write))
        else $error("p_bypass_r3");

    // R4: priority with only reads still takes the bus for a read
    p_read_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && grant && wr_first && !has_write && pend_count != '0)
        |=> (busy && !sel_is_write))
        else $error("p_read_fallback_r4");

    // R10: running record is stable while owned
    p_sel_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(sel_tag) && $stable(sel_is_write)))
        else $error("p_sel_stable_r10");
endmodule

// File: tb/test_data_tenure_sched.sv
module test_data_tenure_sched;
    localparam int DEPTH = 2;
    localparam int TAG_W = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0, enq_is_write = 1'b0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic grant = 1'b0, wr_first = 1'b0, done = 1'b0;
    logic bus_busy, sel_is_write, deq_pulse, ovf_err;
    logic [TAG_W-1:0] sel_tag;
    logic [CNT_W-1:0] pend_count;

    int checks = 0;
    int errors = 0;

    // Reference queue built from the requirements
    int m_tag [DEPTH];
    int m_wr  [DEPTH];
    int m_cnt = 0;
    int m_busy = 0;
    int m_cur = 0;
    int m_ovf = 0;

    always #5 clk = ~clk;

    data_tenure_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_data_tenure_sched (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_is_write(enq_is_write), .enq_tag(enq_tag),
        .grant(grant), .wr_first(wr_first), .done(done),
        .bus_busy(bus_busy), .sel_tag(sel_tag), .sel_is_write(sel_is_write),
        .deq_pulse(deq_pulse), .pend_count(pend_count), .ovf_err(ovf_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Index of the record a grant would start
    function automatic int pick(input int prio);
        if (prio != 0)
            for (int i = 0; i < m_cnt; i++)
                if (m_wr[i] != 0) return i;
        return 0;
    endfunction

    // Advance the reference by one clock with the given inputs
    function automatic void model_step(input int e, input int w, input int t,
                                       input int g, input int o, input int d);
        int take;
        int cap;
        take = (m_busy == 0 && g != 0 && m_cnt > 0) ? 1 : 0;
        cap = 0;
        if (take != 0) m_cur = pick(o);
        if (m_busy != 0 && d != 0) begin
            for (int i = m_cur; i < DEPTH - 1; i++) begin
                m_tag[i] = m_tag[i+1];
                m_wr[i]  = m_wr[i+1];
            end
            m_cnt--;
            m_busy = 0;
        end
        if (e != 0) begin
            if (m_cnt < DEPTH) begin
                m_tag[m_cnt] = t;
                m_wr[m_cnt]  = w;
                m_cnt++;
            end else cap = 1;
        end
        m_ovf = cap;
        if (take != 0) m_busy = 1;
    endfunction

    task automatic compare_outputs();
        check("R5 bus_busy", int'(bus_busy), m_busy);
        check("R1/R9 pend_count", int'(pend_count), m_cnt);
        check("R8 ovf_err", int'(ovf_err), m_ovf);
        check("R2/R3 sel_tag", int'(sel_tag), (m_busy != 0) ? m_tag[m_cur] : 0);
        check("R3/R4 sel_is_write", int'(sel_is_write), (m_busy != 0) ? m_wr[m_cur] : 0);
    endtask

    // One clock: drive after the falling edge, check the registers after the next one
    task automatic tick(input int e, input int w, input int t,
                        input int g, input int o, input int d);
        enq_valid = e[0]; enq_is_write = w[0]; enq_tag = TAG_W'(t);
        grant = g[0]; wr_first = o[0]; done = d[0];
        #1;
        check("R10 deq_pulse", int'(deq_pulse), (m_busy != 0 && d != 0) ? 1 : 0);
        @(posedge clk);
        model_step(e, w, t, g, o, d);
        @(negedge clk);
        compare_outputs();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R1 reset count", int'(pend_count), 0);
        check("R5 reset busy", int'(bus_busy), 0);
        check("R8 reset ovf", int'(ovf_err), 0);

        // R6: grant while empty
        tick(0, 0, 0, 1, 0, 0);
        check("R6 empty grant busy", int'(bus_busy), 0);
        tick(0, 0, 0, 1, 1, 0);
        check("R6 empty grant count", int'(pend_count), 0);

        // Fill with read 1 then write 2, then overflow with read 3
        tick(1, 0, 1, 0, 0, 0);
        tick(1, 1, 2, 0, 0, 0);
        tick(1, 0, 3, 0, 0, 0);
        check("R8 drop flag", int'(ovf_err), 1);
        check("R8 count kept", int'(pend_count), 2);
        tick(0, 0, 0, 0, 0, 0);
        check("R8 flag one cycle", int'(ovf_err), 0);

        // R3: bypass the older read
        tick(0, 0, 0, 1, 1, 0);
        check("R3 bypass tag", int'(sel_tag), 2);
        check("R3 bypass write", int'(sel_is_write), 1);
        // R10: grant while busy is ignored, selection stable
        tick(0, 0, 0, 1, 0, 0);
        check("R10 hold tag", int'(sel_tag), 2);
        check("R10 hold busy", int'(bus_busy), 1);
        tick(0, 0, 0, 0, 0, 1);
        check("R10 release", int'(bus_busy), 0);
        // R7: survivor is the read
        tick(0, 0, 0, 1, 0, 0);
        check("R7 survivor tag", int'(sel_tag), 1);
        // R9: full while running, push during completion
        tick(1, 0, 5, 0, 0, 0);
        check("R1 full", int'(pend_count), 2);
        tick(1, 0, 6, 0, 0, 1);
        check("R9 count", int'(pend_count), 2);
        check("R9 no drop", int'(ovf_err), 0);
        // R2: in order, reads 5 then 6
        tick(0, 0, 0, 1, 0, 0);
        check("R2 oldest first", int'(sel_tag), 5);
        tick(0, 0, 0, 0, 0, 1);
        // R4: priority with only a read held
        tick(0, 0, 0, 1, 1, 0);
        check("R4 read taken", int'(bus_busy), 1);
        check("R4 read tag", int'(sel_tag), 6);
        check("R4 read type", int'(sel_is_write), 0);
        tick(0, 0, 0, 0, 0, 1);
        check("R6 drained", int'(pend_count), 0);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            tick(($urandom % 10) < 4 ? 1 : 0, int'($urandom % 2), int'($urandom % 16),
                 ($urandom % 10) < 3 ? 1 : 0, ($urandom % 10) < 3 ? 1 : 0,
                 ($urandom % 10) < 3 ? 1 : 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule